// File: doc/BRIEF.md
# Hashed MAC Learning Table

This block is the address table of a small layer-2 switch. Every received frame presents one request carrying its source address, destination address and ingress port. The source address is learned against the ingress port, and the destination address is resolved either to one egress port or to a flood decision. Each 48-bit address is reduced to a 16-bit hash. Its low bits select a bucket, and the remaining high bits are kept as a short tag. The key side holds only a valid bit and that tag per bucket. A hit yields a pointer into a separate port memory, which holds the egress port number.

The table accepts one request on every clock. Each result appears a fixed two cycles later, however many entries are filled. A bucket that already holds a different tag is never overwritten, so learning can be refused on a collision. A status output reports when every bucket is occupied. A flush input empties the whole table in one cycle.

Top module: `mac_learn_table`

## Requirements
- R1: The hash is a CRC-16 with polynomial 0x8005 and initial value 0xFFFF, taken over the 48 address bits most significant bit first, without reflection or final XOR. The low IDX_W bits (default 10) select the bucket, and the upper 16-IDX_W bits are the tag that is stored and compared.
- R2: A request may be presented on every cycle. For a request sampled at clock edge k, `res_valid_o` is high after edge k+1, and it is low in cycles with no request two edges earlier.
- R3: A source address whose bucket is empty is learned together with the ingress port of its frame.
- R4: A unicast destination that matches a stored bucket and tag gives `res_flood_o`=0 and `res_port_o` equal to the port stored for that entry.
- R5: A unicast destination with no matching entry gives `res_flood_o`=1 and `res_port_o`=0.
- R6: A destination with the group bit set (bit 40, the least significant bit of the first octet) always gives a flood result with port 0, whatever the table holds.
- R7: A known source address seen on a different port has its stored port replaced by the new one.
- R8: A source address whose bucket holds a different tag is not learned, and the existing entry keeps its tag and port.
- R9: `full_o` is high exactly when all 2^IDX_W buckets are occupied. No new address is learned while it is high.
- R10: `flush_i` empties every bucket at the next edge and drops `full_o`. A frame whose learning write falls on that same edge (its request one cycle before) is not learned.
- R11: After reset the table is empty, and both `res_valid_o` and `full_o` are low.
- R12: A frame's destination lookup sees the table as it was before that frame's own source is learned. Later frames see the learned entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Empty the whole table |
| req_valid_i | input | 1 | Request present this cycle |
| req_smac_i | input | 48 | Source address of the frame |
| req_dmac_i | input | 48 | Destination address of the frame |
| req_port_i | input | PORT_W | Ingress port of the frame |
| res_valid_o | output | 1 | Result present |
| res_flood_o | output | 1 | Send to all ports |
| res_port_o | output | PORT_W | Egress port when not flooding, else 0 |
| full_o | output | 1 | Every bucket occupied |

## Verification
A request driven before edge k has its result registered at edge k+1. The bench samples it at the falling edge that follows, two falling edges after the request was driven. The learning write of that request lands on the same edge k+1. A lookup issued afterwards therefore sees the write, while the frame's own lookup does not. `full_o` and the effect of a flush are read one falling edge after the edge that updates them. The back-to-back test checks three results on three consecutive falling edges.

// File: rtl/mlt_pkg.sv
package mlt_pkg;
    localparam int MAC_W     = 48;
    localparam int HASH_W    = 16;
    localparam int GROUP_BIT = 40;
    localparam logic [HASH_W-1:0] CRC_POLY = 16'h8005;
    localparam logic [HASH_W-1:0] CRC_SEED = 16'hFFFF;
endpackage

// File: rtl/mlt_hash.sv
module mlt_hash
    import mlt_pkg::*;
(
    input  logic [MAC_W-1:0]  mac_i,
    output logic [HASH_W-1:0] hash_o
);
    always_comb begin
        logic [HASH_W-1:0] crc;
        logic              fb;
        crc = CRC_SEED;
        for (int i = MAC_W - 1; i >= 0; i--) begin
            fb  = crc[HASH_W-1] ^ mac_i[i];
            crc = {crc[HASH_W-2:0], 1'b0};
            if (fb) crc = crc ^ CRC_POLY;
        end
        hash_o = crc;
    end
endmodule

// File: rtl/mlt_key_store.sv
module mlt_key_store #(
    parameter int IDX_W = 10,
    parameter int TAG_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             flush_i,
    input  logic             learn_en_i,
    input  logic [IDX_W-1:0] learn_idx_i,
    input  logic [TAG_W-1:0] learn_tag_i,
    output logic             learn_match_o,
    output logic             learn_free_o,
    input  logic [IDX_W-1:0] look_idx_i,
    input  logic [TAG_W-1:0] look_tag_i,
    output logic             look_hit_o,
    output logic [IDX_W-1:0] look_ptr_o,
    output logic             full_o
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int CNT_W = IDX_W + 1;

    logic             vld_q [DEPTH];
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             wr_new;

    assign learn_free_o  = !vld_q[learn_idx_i];
    assign learn_match_o = vld_q[learn_idx_i] && (tag_q[learn_idx_i] == learn_tag_i);
    assign wr_new        = learn_en_i && learn_free_o && !flush_i;

    assign look_hit_o = vld_q[look_idx_i] && (tag_q[look_idx_i] == look_tag_i);
    assign look_ptr_o = look_idx_i;
    assign full_o     = (cnt_q == CNT_W'(DEPTH));

    always_comb begin
        cnt_d = cnt_q;
        if (flush_i)     cnt_d = '0;
        else if (wr_new) cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                vld_q[i] <= 1'b0;
                tag_q[i] <= '0;
            end
        end else begin
            cnt_q <= cnt_d;
            if (flush_i) begin
                for (int i = 0; i < DEPTH; i++) vld_q[i] <= 1'b0;
            end else if (wr_new) begin
                vld_q[learn_idx_i] <= 1'b1;
                tag_q[learn_idx_i] <= learn_tag_i;
            end
        end
    end

    // R9: occupancy never passes the bucket count
    p_count_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CNT_W'(DEPTH));

    // R8: an occupied bucket with another tag is left alone
    p_no_overwrite_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (learn_en_i && !flush_i && vld_q[learn_idx_i] && (tag_q[learn_idx_i] != learn_tag_i))
        |=> (vld_q[$past(learn_idx_i)] && (tag_q[$past(learn_idx_i)] == $past(tag_q[learn_idx_i]))));

    // R10: flush leaves the table empty
    p_flush_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (cnt_q == '0) && !full_o);
endmodule

// File: rtl/mlt_port_store.sv
module mlt_port_store #(
    parameter int IDX_W  = 10,
    parameter int PORT_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_ptr_i,
    input  logic [PORT_W-1:0] wr_port_i,
    input  logic [IDX_W-1:0]  rd_ptr_i,
    output logic [PORT_W-1:0] rd_port_o
);
    localparam int DEPTH = 1 << IDX_W;

    logic [PORT_W-1:0] mem_q [DEPTH];

    assign rd_port_o = mem_q[rd_ptr_i];

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en_i) begin
            mem_q[wr_ptr_i] <= wr_port_i;
        end
    end

    // R7: a write (new entry or station move) lands in the addressed slot
    p_port_written_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> (mem_q[$past(wr_ptr_i)] == $past(wr_port_i)));
endmodule

// File: rtl/mac_learn_table.sv
module mac_learn_table
    import mlt_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int PORT_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              flush_i,
    input  logic              req_valid_i,
    input  logic [47:0]       req_smac_i,
    input  logic [47:0]       req_dmac_i,
    input  logic [PORT_W-1:0] req_port_i,
    output logic              res_valid_o,
    output logic              res_flood_o,
    output logic [PORT_W-1:0] res_port_o,
    output logic              full_o
);
    localparam int TAG_W = HASH_W - IDX_W;

    typedef struct packed {
        logic              vld;
        logic [HASH_W-1:0] sh;
        logic [HASH_W-1:0] dh;
        logic              grp;
        logic [PORT_W-1:0] port;
    } stage_t;

    typedef struct packed {
        logic              vld;
        logic              flood;
        logic [PORT_W-1:0] port;
    } result_t;

    stage_t  st_d, st_q;
    result_t rs_d, rs_q;

    logic [HASH_W-1:0] s_hash, d_hash;
    logic              learn_match, learn_free;
    logic              look_hit;
    logic [IDX_W-1:0]  look_ptr;
    logic [PORT_W-1:0] rd_port;
    logic              port_wr;

    mlt_hash u_src_hash (.mac_i(req_smac_i), .hash_o(s_hash));
    mlt_hash u_dst_hash (.mac_i(req_dmac_i), .hash_o(d_hash));

    mlt_key_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_keys (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .flush_i      (flush_i),
        .learn_en_i   (st_q.vld),
        .learn_idx_i  (st_q.sh[IDX_W-1:0]),
        .learn_tag_i  (st_q.sh[HASH_W-1:IDX_W]),
        .learn_match_o(learn_match),
        .learn_free_o (learn_free),
        .look_idx_i   (st_q.dh[IDX_W-1:0]),
        .look_tag_i   (st_q.dh[HASH_W-1:IDX_W]),
        .look_hit_o   (look_hit),
        .look_ptr_o   (look_ptr),
        .full_o       (full_o)
    );

    assign port_wr = st_q.vld && !flush_i && (learn_match || learn_free);

    mlt_port_store #(.IDX_W(IDX_W), .PORT_W(PORT_W)) u_ports (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (port_wr),
        .wr_ptr_i (st_q.sh[IDX_W-1:0]),
        .wr_port_i(st_q.port),
        .rd_ptr_i (look_ptr),
        .rd_port_o(rd_port)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = req_valid_i;
        st_d.sh   = s_hash;
        st_d.dh   = d_hash;
        st_d.grp  = req_dmac_i[GROUP_BIT];
        st_d.port = req_port_i;

        rs_d       = rs_q;
        rs_d.vld   = st_q.vld;
        rs_d.flood = st_q.grp || !look_hit;
        rs_d.port  = rs_d.flood ? '0 : rd_port;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
            rs_q <= '0;
        end else begin
            st_q <= st_d;
            rs_q <= rs_d;
        end
    end

    assign res_valid_o = rs_q.vld;
    assign res_flood_o = rs_q.flood;
    assign res_port_o  = rs_q.port;

    // R2: fixed two-cycle latency
    p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |-> ##2 res_valid_o);
    p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |-> ##2 !res_valid_o);

    // R6: group destinations always flood
    p_group_floods_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_dmac_i[GROUP_BIT]) |-> ##2 (res_flood_o && (res_port_o == '0)));

    // R4: a key hit on a unicast destination forwards
    p_hit_forwards_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.vld && !st_q.grp && look_hit) |=> !res_flood_o);
endmodule

// File: tb/tb_mac_learn_table.sv
`timescale 1ns/1ps
module tb_mac_learn_table;
    localparam int IDX_W  = 4;
    localparam int PORT_W = 4;

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic              flush_i = 1'b0;
    logic              req_valid_i = 1'b0;
    logic [47:0]       req_smac_i = '0;
    logic [47:0]       req_dmac_i = '0;
    logic [PORT_W-1:0] req_port_i = '0;
    logic              res_valid_o, res_flood_o, full_o;
    logic [PORT_W-1:0] res_port_o;

    int vectors = 0;
    int fails   = 0;

    always #2 clk_i = ~clk_i;

    mac_learn_table #(.IDX_W(IDX_W), .PORT_W(PORT_W)) dut (.*);

    function automatic logic [15:0] crc16(input logic [47:0] m);
        logic [15:0] c = 16'hFFFF;
        for (int i = 47; i >= 0; i--) begin
            logic fb = c[15] ^ m[i];
            c = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h8005;
        end
        return c;
    endfunction

    // nth unicast address that falls in bucket b (R1)
    function automatic logic [47:0] mb(input int b, input int nth);
        int seen = 0;
        for (int k = 0; k < 65536; k++) begin
            logic [47:0] m = {32'h02AB_CD00, 16'(k)};
            if (int'(crc16(m) & 16'((1 << IDX_W) - 1)) == b) begin
                if (seen == nth) return m;
                seen++;
            end
        end
        return '0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_res(input bit ef, input logic [PORT_W-1:0] ep, input string req);
        logic [63:0] act = {res_valid_o, res_flood_o, res_port_o};
        logic [63:0] exp = {1'b1, ef, ep};
        check(act == exp, req, act, exp);
    endtask

    // drive one frame, sample its result two falling edges later
    task automatic frame(input logic [47:0] s, input logic [47:0] d, input logic [PORT_W-1:0] p,
                         input bit ef, input logic [PORT_W-1:0] ep, input string req);
        @(negedge clk_i);
        req_valid_i = 1'b1; req_smac_i = s; req_dmac_i = d; req_port_i = p;
        @(negedge clk_i);
        req_valid_i = 1'b0;
        @(negedge clk_i);
        check_res(ef, ep, req);
    endtask

    task automatic do_flush();
        @(negedge clk_i); flush_i = 1'b1;
        @(negedge clk_i); flush_i = 1'b0;
    endtask

    task automatic t_reset();
        check({res_valid_o, full_o} == 2'b00, "R11", {res_valid_o, full_o}, 0);
    endtask

    task automatic t_learn();
        frame(mb(1,0), mb(2,0), 3, 1, 0, "R5 unknown dest floods");
        frame(mb(2,0), mb(1,0), 2, 0, 3, "R3 R4 learned source forwards");
    endtask

    task automatic t_group();
        frame(mb(2,0), 48'hFFFF_FFFF_FFFF, 2, 1, 0, "R6 broadcast");
        frame(mb(2,0), {8'h01, 40'h00_5E00_0001}, 2, 1, 0, "R6 multicast");
    endtask

    task automatic t_move();
        frame(mb(1,0), mb(2,0), 6, 0, 2, "R4");
        frame(mb(2,0), mb(1,0), 2, 0, 6, "R7 station move");
    endtask

    task automatic t_collide();
        frame(mb(1,1), mb(2,0), 9, 0, 2, "R8");
        frame(mb(2,0), mb(1,1), 2, 1, 0, "R8 R1 colliding tag not learned");
        frame(mb(2,0), mb(1,0), 2, 0, 6, "R8 existing entry kept");
    endtask

    task automatic t_self();
        frame(mb(3,0), mb(3,0), 4, 1, 0, "R12 own learn not seen");
        frame(mb(2,0), mb(3,0), 2, 0, 4, "R12 seen by later frame");
    endtask

    task automatic t_pipe();
        @(negedge clk_i);
        req_valid_i = 1'b1; req_smac_i = mb(2,0); req_dmac_i = mb(1,0); req_port_i = 2;
        @(negedge clk_i);
        req_dmac_i = mb(7,0);
        @(negedge clk_i);
        req_dmac_i = 48'hFFFF_FFFF_FFFF;
        check_res(0, 6, "R2 back-to-back first");
        @(negedge clk_i);
        req_valid_i = 1'b0;
        check_res(1, 0, "R2 back-to-back second");
        @(negedge clk_i);
        check_res(1, 0, "R2 back-to-back third");
        @(negedge clk_i);
        check(!res_valid_o, "R2 idle", res_valid_o, 0);
    endtask

    task automatic t_flush_race();
        @(negedge clk_i);
        req_valid_i = 1'b1; req_smac_i = mb(4,0); req_dmac_i = mb(2,0); req_port_i = 7;
        @(negedge clk_i);
        req_valid_i = 1'b0; flush_i = 1'b1;
        @(negedge clk_i);
        flush_i = 1'b0;
        check_res(0, 2, "R10 lookup before flush");
        frame(mb(2,0), mb(4,0), 2, 1, 0, "R10 racing learn dropped");
        frame(mb(2,0), mb(1,0), 2, 1, 0, "R10 flushed entry gone");
        check(!full_o, "R10 full low", full_o, 0);
    endtask

    task automatic t_full();
        do_flush();
        for (int b = 0; b < (1 << IDX_W); b++) begin
            if (b == (1 << IDX_W) - 1)
                check(!full_o, "R9 not yet full", full_o, 0);
            frame(mb(b,0), 48'hFFFF_FFFF_FFFF, PORT_W'(b), 1, 0, "R6 fill");
        end
        check(full_o, "R9 full raised", full_o, 1);
        frame(mb(5,1), mb(5,0), 1, 0, 5, "R9 R12 lookup when full");
        frame(mb(6,0), mb(5,1), 6, 1, 0, "R9 no learn when full");
        frame(mb(6,0), mb(15,0), 6, 0, 15, "R9 entries kept");
        do_flush();
        @(negedge clk_i);
        check(!full_o, "R10 flush drops full", full_o, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk_i);
        vectors++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_learn();
        t_group();
        t_move();
        t_collide();
        t_self();
        t_pipe();
        t_flush_race();
        t_full();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule